// File: doc/BRIEF.md
# Dual-bridge phase-shift PWM generator

This block drives the eight gates of a dual active bridge: two full bridges, four legs in all. Each leg follows a symmetric up-down carrier of the same period. The leg's raw PWM is high through the upper half of the carrier, which gives a 50% duty cycle. Leg 0 is the master. Leg 1 lags it by `lag_a`, leg 2 lags it by the signed word `bridge_shift`, and leg 3 lags it by `lag_b + bridge_shift`. Phase is counted in carrier steps, and one full carrier cycle is `2*period` steps, which is 360 degrees.

The inter-bridge shift is a two's complement value. When it is negative, leg 2 leads the master, so the second bridge leads and power flows backwards. The shift is reduced modulo `2*period` before use, so reverse power flow uses the same load path as forward flow.

The phase words take effect only when the master carrier returns to zero. Each leg then turns its raw PWM into a high-side and low-side gate pair with equal dead time on both edges. A trip input forces every gate low at once and keeps them low until a trip clear. The latch comes out of reset in the tripped state. All counting advances only on cycles where `tick_en` is high.

Top module: `dab_phase_pwm`

## Requirements
- R1: After reset all eight gate outputs are low. They stay low, with the trip latch set, until `trip_clr` is pulsed while `trip` is low.
- R2: The master position steps 0,1,...,2*period-1 and then returns to 0, advancing once per cycle with `tick_en` high. While `tick_en` is low, no position, dead-time counter or gate output changes.
- R3: The raw PWM of a leg at position p is high when floor(period/2) <= p < 2*period - floor(period/2). For an even period this is a 50% duty cycle.
- R4: New values on `lag_a`, `lag_b` and `bridge_shift` affect the legs only after the master position next wraps to zero. An edge already scheduled within the current master cycle keeps the old offset.
- R5: Leg 1's high-side gate rises `lag_a` cycles after leg 0's. Leg 3's rises (`lag_b + bridge_shift`) mod 2*period cycles after leg 0's.
- R6: `bridge_shift` is two's complement and is wrapped modulo 2*period. A value of -d makes leg 2's high-side gate rise 2*period-d cycles after leg 0's, which means d cycles ahead of it. Zero gives coincident edges.
- R7: After every raw PWM edge, the gate that was on turns off one tick later. The opposite gate turns on `dead_cnt` ticks after that. The gap is exactly `dead_cnt`, and the high-side pulse lasts the raw high time minus `dead_cnt`. The two gates of a leg are never high together.
- R8: `trip` high forces all gates low in the same cycle. The latch then holds them low until `trip_clr` arrives with `trip` low. `trip` wins when both are high.
- Gate bit mapping: bit i of `gate_hi` and of `gate_lo` belongs to leg i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances carriers and dead-time counters |
| period | input | CNT_W | Half carrier length in steps |
| dead_cnt | input | DB_W | Dead time in ticks |
| lag_a | input | CNT_W | Lag of leg 1 in steps (0..period) |
| lag_b | input | CNT_W | Lag of leg 3 relative to leg 2 in steps (0..period) |
| bridge_shift | input | CNT_W+1 | Signed lag of leg 2 in steps (-period..period) |
| trip | input | 1 | Fault input, forces all gates low |
| trip_clr | input | 1 | Releases the trip latch |
| gate_hi | output | 4 | High-side gates, bit i is leg i |
| gate_lo | output | 4 | Low-side gates, bit i is leg i |

## Verification
A wrong loaded leg position appears as a fixed error in the delay between edges from the first carrier cycle after a master wrap. A cycle-exact reference model therefore flags it within one master period, and the delay measurements name the leg. A dead-time counter that restarts wrongly changes the gap or the pulse width on the very next raw edge. A trip latch in the wrong state shows immediately as gates that are on when they should be off, or the reverse. Since the phase words are latched only at the wrap, a premature load is caught by sampling an edge that is already scheduled in the same master cycle.

// File: rtl/dab_pwm_pkg.sv
package dab_pwm_pkg;
    localparam int LEGS = 4;

    typedef enum logic [1:0] {
        LEG_MASTER = 2'd0,
        LEG_B1_LAG = 2'd1,
        LEG_B2_REF = 2'd2,
        LEG_B2_LAG = 2'd3
    } leg_e;
endpackage

// File: rtl/dab_carrier.sv
module dab_carrier
    import dab_pwm_pkg::*;
#(
    parameter  int CNT_W = 16,
    localparam int PW    = CNT_W + 1,
    localparam int SW    = CNT_W + 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [CNT_W-1:0]              period,
    input  logic [CNT_W-1:0]              lag_a,
    input  logic [CNT_W-1:0]              lag_b,
    input  logic signed [CNT_W:0]         shift,
    output logic [PW-1:0]                 mpos_o,
    output logic [LEGS-2:0][PW-1:0]       lpos_o,
    output logic [LEGS-2:0][PW-1:0]       off_o
);
    typedef struct packed {
        logic [PW-1:0]           mpos;
        logic [LEGS-2:0][PW-1:0] lpos;
        logic [LEGS-2:0][PW-1:0] off;
    } car_t;

    car_t s_d, s_q;

    logic [PW-1:0]           full_w;
    logic [PW-1:0]           last_w;
    logic [LEGS-2:0][SW-1:0] req_w;

    // reduce a signed lag into 0 .. full-1 (one correction covers the legal ranges)
    function automatic logic [PW-1:0] wrap_pos(input logic signed [SW-1:0] v,
                                               input logic [PW-1:0] full);
        logic signed [SW-1:0] f;
        f = $signed({2'b00, full});
        if (v < 0)
            return PW'(v + f);
        else if (v >= f)
            return PW'(v - f);
        return PW'(v);
    endfunction

    assign full_w   = {period, 1'b0};
    assign last_w   = full_w - 1'b1;
    assign req_w[0] = {3'b000, lag_a};
    assign req_w[1] = {{2{shift[CNT_W]}}, shift};
    assign req_w[2] = SW'($signed({3'b000, lag_b}) + $signed({{2{shift[CNT_W]}}, shift}));

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (s_q.mpos >= last_w) begin
                s_d.mpos = '0;
                for (int i = 0; i < LEGS - 1; i++) begin
                    s_d.off[i]  = wrap_pos($signed(req_w[i]), full_w);
                    s_d.lpos[i] = (s_d.off[i] == '0) ? '0 : full_w - s_d.off[i];
                end
            end else begin
                s_d.mpos = s_q.mpos + 1'b1;
                for (int i = 0; i < LEGS - 1; i++) begin
                    s_d.lpos[i] = (s_q.lpos[i] >= last_w) ? '0 : s_q.lpos[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign mpos_o = s_q.mpos;
    assign lpos_o = s_q.lpos;
    assign off_o  = s_q.off;
endmodule

// File: rtl/dab_deadband.sv
module dab_deadband #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            raw,
    input  logic [DB_W-1:0] db,
    output logic            hi,
    output logic            lo
);
    typedef struct packed {
        logic            prev;
        logic [DB_W-1:0] cnt;
    } db_t;

    db_t s_d, s_q;
    logic settled_w;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.prev = raw;
            if (raw != s_q.prev)
                s_d.cnt = '0;
            else if (s_q.cnt < db)
                s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign settled_w = (s_q.cnt >= db);
    assign hi        = s_q.prev & settled_w;
    assign lo        = ~s_q.prev & settled_w;
endmodule

// File: rtl/dab_trip.sv
module dab_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic clr,
    output logic block
);
    logic hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (trip)
            hold_d = 1'b1;
        else if (clr)
            hold_d = 1'b0;
    end

    // comes out of reset tripped: gates stay off until software-free explicit release
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b1;
        else
            hold_q <= hold_d;
    end

    assign block = hold_q | trip;
endmodule

// File: rtl/dab_phase_pwm.sv
module dab_phase_pwm
    import dab_pwm_pkg::*;
#(
    parameter  int CNT_W = 16,
    parameter  int DB_W  = 8,
    localparam int PW    = CNT_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic [CNT_W-1:0]      period,
    input  logic [DB_W-1:0]       dead_cnt,
    input  logic [CNT_W-1:0]      lag_a,
    input  logic [CNT_W-1:0]      lag_b,
    input  logic signed [CNT_W:0] bridge_shift,
    input  logic                  trip,
    input  logic                  trip_clr,
    output logic [3:0]            gate_hi,
    output logic [3:0]            gate_lo
);
    logic [PW-1:0]           mpos_w;
    logic [LEGS-2:0][PW-1:0] lpos_w;
    logic [LEGS-2:0][PW-1:0] off_w;
    logic [LEGS-1:0][PW-1:0] leg_pos_w;
    logic [LEGS-1:0]         raw_w;
    logic [LEGS-1:0]         hi_w;
    logic [LEGS-1:0]         lo_w;
    logic [PW-1:0]           full_w;
    logic [PW-1:0]           half_w;
    logic                    block_w;

    dab_carrier #(.CNT_W(CNT_W)) car_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .period (period),
        .lag_a  (lag_a),
        .lag_b  (lag_b),
        .shift  (bridge_shift),
        .mpos_o (mpos_w),
        .lpos_o (lpos_w),
        .off_o  (off_w)
    );

    assign full_w = {period, 1'b0};
    assign half_w = PW'(period >> 1);

    generate
        for (genvar g = 0; g < LEGS; g++) begin : g_leg
            if (g == 0) begin : g_master
                assign leg_pos_w[g] = mpos_w;
            end else begin : g_slave
                assign leg_pos_w[g] = lpos_w[g-1];
            end

            // rising compare crossing sets, falling compare crossing clears
            assign raw_w[g] = (leg_pos_w[g] >= half_w) && (leg_pos_w[g] < full_w - half_w);

            dab_deadband #(.DB_W(DB_W)) db_i (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick_en),
                .raw   (raw_w[g]),
                .db    (dead_cnt),
                .hi    (hi_w[g]),
                .lo    (lo_w[g])
            );
        end
    endgenerate

    dab_trip trip_i (
        .clk   (clk),
        .rst_n (rst_n),
        .trip  (trip),
        .clr   (trip_clr),
        .block (block_w)
    );

    assign gate_hi = hi_w & {LEGS{~block_w}};
    assign gate_lo = lo_w & {LEGS{~block_w}};
endmodule

// File: rtl/dab_phase_pwm_chk.sv
module dab_phase_pwm_chk
    import dab_pwm_pkg::*;
#(
    parameter  int CNT_W = 16,
    localparam int PW    = CNT_W + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick_en,
    input logic [CNT_W-1:0]        period,
    input logic                    trip,
    input logic [3:0]              gate_hi,
    input logic [3:0]              gate_lo,
    input logic [PW-1:0]           mpos_w,
    input logic [LEGS-2:0][PW-1:0] lpos_w,
    input logic [LEGS-2:0][PW-1:0] off_w
);
    logic [PW-1:0] full_c;
    assign full_c = {period, 1'b0};

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == 4'b0000);

    assert_trip_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (gate_hi == 4'b0000 && gate_lo == 4'b0000));

    assert_trip_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trip) |-> (gate_hi == 4'b0000 && gate_lo == 4'b0000));

    assert_master_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && mpos_w >= full_c - 1'b1) |=> (mpos_w == '0));

    assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(mpos_w));

    generate
        for (genvar g = 0; g < LEGS - 1; g++) begin : g_sync
            logic [PW:0] sum_g;
            assign sum_g = {1'b0, lpos_w[g]} + {1'b0, off_w[g]};
            // at master zero each leg sits exactly its offset behind
            assert_sync_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (tick_en && mpos_w >= full_c - 1'b1) |=>
                    ($changed(period) || sum_g == '0 || sum_g == {1'b0, full_c}));
        end
    endgenerate
endmodule

bind dab_phase_pwm dab_phase_pwm_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .period  (period),
    .trip    (trip),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .mpos_w  (mpos_w),
    .lpos_w  (lpos_w),
    .off_w   (off_w)
);

// File: tb/dab_phase_pwm_tb.sv
`timescale 1ns/1ps
module dab_phase_pwm_tb_top;
    localparam int CNT_W = 16;
    localparam int DB_W  = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  tick_en = 1'b1;
    logic [CNT_W-1:0]      period = 16'd40;
    logic [DB_W-1:0]       dead_cnt = 8'd3;
    logic [CNT_W-1:0]      lag_a = 16'd10;
    logic [CNT_W-1:0]      lag_b = 16'd20;
    logic signed [CNT_W:0] bridge_shift = 17'sd15;
    logic                  trip = 1'b0;
    logic                  trip_clr = 1'b0;
    logic [3:0]            gate_hi;
    logic [3:0]            gate_lo;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dab_phase_pwm #(.CNT_W(CNT_W), .DB_W(DB_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .period       (period),
        .dead_cnt     (dead_cnt),
        .lag_a        (lag_a),
        .lag_b        (lag_b),
        .bridge_shift (bridge_shift),
        .trip         (trip),
        .trip_clr     (trip_clr),
        .gate_hi      (gate_hi),
        .gate_lo      (gate_lo)
    );

    // ---------------- behavioural reference model ----------------
    int m_pos;
    int m_lpos [3];
    int m_off  [3];
    int m_prev [4];
    int m_cnt  [4];
    int m_trip;

    function automatic int md(input int x, input int m);
        return ((x % m) + m) % m;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pos = 0;
            for (int k = 0; k < 3; k++) begin m_lpos[k] = 0; m_off[k] = 0; end
            for (int k = 0; k < 4; k++) begin m_prev[k] = 0; m_cnt[k] = 0; end
            m_trip = 1;
        end else begin
            int full, half, nt;
            full = 2 * int'(period);
            half = int'(period) / 2;
            nt = trip ? 1 : (trip_clr ? 0 : m_trip);
            if (tick_en) begin
                for (int k = 0; k < 4; k++) begin
                    int p, r;
                    p = (k == 0) ? m_pos : m_lpos[k-1];
                    r = (p >= half && p < full - half) ? 1 : 0;
                    if (r != m_prev[k]) m_cnt[k] = 0;
                    else if (m_cnt[k] < int'(dead_cnt)) m_cnt[k]++;
                    m_prev[k] = r;
                end
                if (m_pos >= full - 1) begin
                    m_pos = 0;
                    m_off[0] = md(int'(lag_a), full);
                    m_off[1] = md(int'(bridge_shift), full);
                    m_off[2] = md(int'(lag_b) + int'(bridge_shift), full);
                    for (int k = 0; k < 3; k++) m_lpos[k] = md(-m_off[k], full);
                end else begin
                    m_pos++;
                    for (int k = 0; k < 3; k++) m_lpos[k] = md(m_lpos[k] + 1, full);
                end
            end
            m_trip = nt;
        end
    end

    // ---------------- edge bookkeeping and per-cycle compare ----------------
    int rise_cyc [4] = '{-1, -1, -1, -1};
    int rise_cnt [4] = '{0, 0, 0, 0};
    int fall_cyc = -1;
    int fall_cnt = 0;
    int lofall_cyc = -1;
    logic [3:0] hi_prev = '0;
    logic [3:0] lo_prev = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 4; k++) begin
                logic eh, el;
                eh = (m_prev[k] == 1) && (m_cnt[k] >= int'(dead_cnt)) && !m_trip && !trip;
                el = (m_prev[k] == 0) && (m_cnt[k] >= int'(dead_cnt)) && !m_trip && !trip;
                checks++;
                if (gate_hi[k] !== eh || gate_lo[k] !== el) begin
                    fails++;
                    $display("FAIL R2/R3/R4/R7 model leg%0d cyc%0d: hi=%b lo=%b expected hi=%b lo=%b",
                             k, cyc, gate_hi[k], gate_lo[k], eh, el);
                end
            end
        end
        for (int k = 0; k < 4; k++) begin
            if (gate_hi[k] && !hi_prev[k]) begin rise_cyc[k] = cyc; rise_cnt[k]++; end
        end
        if (!gate_hi[0] && hi_prev[0]) begin fall_cyc = cyc; fall_cnt++; end
        if (!gate_lo[0] && lo_prev[0]) lofall_cyc = cyc;
        hi_prev = gate_hi;
        lo_prev = gate_lo;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic meas(input int k, input int exp, input string tag);
        int c0, ck, t0, d;
        c0 = rise_cnt[0];
        wait (rise_cnt[0] != c0);
        t0 = rise_cyc[0];
        ck = rise_cnt[k];
        if (rise_cyc[k] == t0) d = 0;
        else begin
            wait (rise_cnt[k] != ck);
            d = rise_cyc[k] - t0;
        end
        check(d == exp, tag, d, exp);
    endtask

    task automatic drive_cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(gate_hi == 4'b0 && gate_lo == 4'b0, "R1 gates low after reset",
              int'({gate_hi, gate_lo}), 0);
        repeat (30) @(negedge clk);
        check(gate_hi == 4'b0 && gate_lo == 4'b0, "R1 gates held low until clear",
              int'({gate_hi, gate_lo}), 0);

        @(posedge clk); #2 trip_clr = 1'b1;
        @(posedge clk); #2 trip_clr = 1'b0;
        drive_cycles(200);

        meas(1, 10, "R5 leg1 lag by lag_a");
        meas(2, 15, "R6 leg2 positive shift");
        meas(3, 35, "R5 leg3 lag_b+shift");

        // R4: change shift after the master edge; the pending leg2 edge keeps old lag
        begin
            int c0, ck, t0, d;
            c0 = rise_cnt[0];
            wait (rise_cnt[0] != c0);
            t0 = rise_cyc[0];
            ck = rise_cnt[2];
            @(posedge clk); #2 bridge_shift = -17'sd25;
            wait (rise_cnt[2] != ck);
            d = rise_cyc[2] - t0;
            check(d == 15, "R4 update deferred to master zero", d, 15);
        end
        drive_cycles(200);
        meas(2, 55, "R6 negative shift leg2 leads by 25");
        meas(3, 75, "R6 leg3 wraps lag_b+shift=-5");

        bridge_shift = 17'sd0;
        drive_cycles(200);
        meas(2, 0, "R6 zero shift coincident");

        bridge_shift = -17'sd40;
        drive_cycles(200);
        meas(2, 40, "R6 shift of -180 deg");
        meas(3, 60, "R5 leg3 lag_b+shift=-20");

        // R7 dead time gap and pulse width, dead_cnt=3
        begin
            int c0, f0;
            c0 = rise_cnt[0];
            wait (rise_cnt[0] != c0);
            check(rise_cyc[0] - lofall_cyc == 3, "R7 dead gap 3", rise_cyc[0] - lofall_cyc, 3);
            f0 = fall_cnt;
            wait (fall_cnt != f0);
            check(fall_cyc - rise_cyc[0] == 37, "R7 high pulse 37", fall_cyc - rise_cyc[0], 37);
        end
        dead_cnt = 8'd0;
        drive_cycles(200);
        begin
            int c0, f0;
            c0 = rise_cnt[0];
            wait (rise_cnt[0] != c0);
            check(rise_cyc[0] - lofall_cyc == 0, "R7 dead gap 0", rise_cyc[0] - lofall_cyc, 0);
            f0 = fall_cnt;
            wait (fall_cnt != f0);
            check(fall_cyc - rise_cyc[0] == 40, "R7 high pulse 40", fall_cyc - rise_cyc[0], 40);
        end
        dead_cnt = 8'd3;
        drive_cycles(200);

        // R2 freeze
        begin
            logic [7:0] snap;
            @(posedge clk); #2 tick_en = 1'b0;
            @(negedge clk);
            snap = {gate_hi, gate_lo};
            repeat (12) @(negedge clk);
            check({gate_hi, gate_lo} == snap, "R2 frozen while tick_en low",
                  int'({gate_hi, gate_lo}), int'(snap));
            @(posedge clk); #2 tick_en = 1'b1;
        end
        drive_cycles(100);

        // R8 trip
        @(posedge clk); #2 trip = 1'b1;
        @(negedge clk);
        check(gate_hi == 4'b0 && gate_lo == 4'b0, "R8 trip forces low",
              int'({gate_hi, gate_lo}), 0);
        @(posedge clk); #2 trip = 1'b0;
        repeat (5) @(negedge clk);
        check(gate_hi == 4'b0 && gate_lo == 4'b0, "R8 trip latched",
              int'({gate_hi, gate_lo}), 0);
        @(posedge clk); #2 trip = 1'b1; trip_clr = 1'b1;
        @(posedge clk); #2 trip = 1'b0; trip_clr = 1'b0;
        repeat (3) @(negedge clk);
        check(gate_hi == 4'b0 && gate_lo == 4'b0, "R8 trip wins over clear",
              int'({gate_hi, gate_lo}), 0);
        @(posedge clk); #2 trip_clr = 1'b1;
        @(posedge clk); #2 trip_clr = 1'b0;
        begin
            int active;
            active = 0;
            repeat (100) begin
                @(negedge clk);
                if ({gate_hi, gate_lo} != 8'b0) active++;
            end
            check(active > 0, "R8 gates resume after clear", active, 1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule